// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests for a processor and turns them into two request outputs: a normal-interrupt line and a fast-interrupt line. Source 0 is the fast line and feeds only the fast output. The next six sources are external request lines. The remaining sources are on-chip peripheral lines, and their count is a parameter. Each source has an enable bit, an edge or level mode, a 3-bit priority and a 32-bit handler vector.

When the processor takes a normal interrupt, it pulses `ack_rd`. In that same cycle it reads `vec_out`, which holds the vector of the highest-priority eligible source. The acknowledge pushes that source's priority onto an in-service stack. From then on, only a source of strictly higher priority can raise `irq_o`. An end-of-interrupt write pops the stack and restores the previous level. If nothing is eligible, a programmable spurious vector is returned instead. A protect bit turns vector reads into pure observations so that a debugger can read the vector safely.

All inputs are assumed synchronous to `clk`. Configuration goes through a write-only port. `cfg_addr[7:5]` selects the operation and `cfg_addr[4:0]` selects the source number.

Top module: `prio_vic`

## Requirements
- R1: After reset every source is disabled, the stack is empty, all vectors and the spurious vector are 0, and `irq_o` and `fiq_o` are low.
- R2: A source whose enable bit is 0 never drives `irq_o` or `fiq_o`. A control write (operation 0) sets priority in `cfg_wdata[2:0]`, edge mode in bit 3 and enable in bit 4.
- R3: `vec_out` shows the vector (operation 1 writes it) of the enabled pending normal source with the highest priority. On a tie, the lowest source number wins.
- R4: `irq_o` is high only when that winner's priority is strictly greater than the top of the in-service stack, or when the stack is empty. An unprotected `ack_rd` with an eligible winner pushes its priority.
- R5: An end-of-interrupt write (operation 4) pops one stack entry, which restores the previous level. On an empty stack it does nothing.
- R6: A level source is pending while its line is high. An edge source latches a rising edge until its vector is acknowledged, or for source 0, until `fiq_ack`.
- R7: An `ack_rd` with no eligible source returns the spurious vector (operation 2) and changes no state.
- R8: Source 0 drives only `fiq_o`, never `irq_o`. `fiq_vec` carries its vector.
- R9: While the protect bit (operation 3, bit 0) is set, `ack_rd` and `fiq_ack` change no stack or pending state.
- R10: When `ack_rd` and an end-of-interrupt write fall in the same cycle, the returned vector is judged against the old stack top. The pop is applied first and then the push, so the stack depth is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fiq_line | input | 1 | Fast interrupt request (source 0) |
| ext_irq | input | 6 | External requests (sources 1 to 6) |
| periph_irq | input | N_PERIPH | Peripheral requests (sources 7 up) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Operation [7:5], source number [4:0] |
| cfg_wdata | input | 32 | Configuration write data |
| ack_rd | input | 1 | Normal vector read / acknowledge |
| fiq_ack | input | 1 | Fast interrupt acknowledge |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| vec_out | output | 32 | Winner vector or spurious vector |
| fiq_vec | output | 32 | Vector of source 0 |

## Verification
The end-of-interrupt write and the vector acknowledge can land in the same clock cycle. The bench provokes this while one interrupt is in service and a higher-priority source is pending, by driving the end-of-interrupt write and `ack_rd` together. The returned vector is checked against the pre-cycle state. The request output afterwards is also checked: it must stay low for the older, lower-priority source until a second end-of-interrupt. That result separates a replace-top stack from a stack that only pops or only pushes.

// File: rtl/prio_vic_pkg.sv
// Package: shared operation codes and control-word field positions for
// the prioritized vectored interrupt controller.
package prio_vic_pkg;
    localparam int ADDR_W = 8;
    localparam int IDX_W  = 5;    // source number field width (max 32 sources)
    localparam int PRIO_W = 3;    // eight priority levels

    typedef enum logic [2:0] {
        OP_CTL  = 3'd0,           // priority / edge / enable
        OP_VEC  = 3'd1,           // per-source handler vector
        OP_SPUR = 3'd2,           // spurious vector
        OP_PROT = 3'd3,           // protect (debug) bit
        OP_EOI  = 3'd4            // end of interrupt
    } cfg_op_e;

    localparam int CTL_EDGE_BIT = PRIO_W;
    localparam int CTL_EN_BIT   = PRIO_W + 1;
endpackage

// File: rtl/vic_src_bank.sv
// Source bank: one slice per source holding the enable, edge mode,
// priority, vector and edge latch. Produces the enabled pending vector.
// Assumes source lines are synchronous to clk.
module vic_src_bank
    import prio_vic_pkg::*;
#(
    parameter int NSRC = 16,
    parameter int PW   = 3,
    parameter int VW   = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NSRC-1:0]          lines,
    input  logic                     ctl_we,
    input  logic                     vec_we,
    input  logic [IDX_W-1:0]         idx,
    input  logic [VW-1:0]            wdata,
    input  logic [NSRC-1:0]          clr,
    output logic [NSRC-1:0]          pend,
    output logic [NSRC-1:0]          en,
    output logic [NSRC-1:0][PW-1:0]  prio,
    output logic [NSRC-1:0][VW-1:0]  vec
);
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        logic          hit;
        logic [PW-1:0] prio_q;
        logic          edge_q;
        logic          en_q;
        logic [VW-1:0] vec_q;
        logic          line_q;
        logic          latch_q;

        assign hit = (idx == IDX_W'(g));

        // Control word capture for this source.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prio_q <= '0;
                edge_q <= 1'b0;
                en_q   <= 1'b0;
            end else if (ctl_we && hit) begin
                prio_q <= wdata[PW-1:0];
                edge_q <= wdata[CTL_EDGE_BIT];
                en_q   <= wdata[CTL_EN_BIT];
            end
        end

        // Handler vector capture for this source.
        always_ff @(posedge clk) begin
            if (!rst_n)                vec_q <= '0;
            else if (vec_we && hit)    vec_q <= wdata;
        end

        // Rising-edge latch; a new edge wins over a clear in the same cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                line_q  <= 1'b0;
                latch_q <= 1'b0;
            end else begin
                line_q  <= lines[g];
                latch_q <= edge_q & ((lines[g] & ~line_q) |
                                     (latch_q & ~clr[g] & ~(ctl_we & hit)));
            end
        end

        assign pend[g] = en_q & (edge_q ? latch_q : lines[g]);
        assign en[g]   = en_q;
        assign prio[g] = prio_q;
        assign vec[g]  = vec_q;
    end
endmodule

// File: rtl/vic_arbiter.sv
// Arbiter: picks the pending normal source (source 0 excluded) with the
// highest priority, lowest source number on ties. Purely combinational.
module vic_arbiter #(
    parameter int NSRC = 16,
    parameter int PW   = 3,
    localparam int SW  = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]          req,
    input  logic [NSRC-1:0][PW-1:0]  prio,
    output logic                     win_valid,
    output logic [SW-1:0]            win_idx,
    output logic [PW-1:0]            win_prio
);
    // Linear scan; strict compare keeps the earliest index on a tie.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_prio  = '0;
        for (int i = 1; i < NSRC; i++) begin
            if (req[i] && (!win_valid || prio[i] > win_prio)) begin
                win_valid = 1'b1;
                win_idx   = SW'(i);
                win_prio  = prio[i];
            end
        end
    end
endmodule

// File: rtl/vic_level_stack.sv
// In-service level stack: holds the priorities being served. A pop is
// applied before a push in the same cycle. Assumes pushes only happen with
// strictly rising levels, so DEPTH = number of levels never overflows.
module vic_level_stack #(
    parameter int PW    = 3,
    parameter int DEPTH = 8,
    localparam int SPW  = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic           pop,
    input  logic [PW-1:0]  push_lvl,
    output logic [PW:0]    cur_eff,   // 0 = empty, else top + 1
    output logic [SPW-1:0] depth
);
    logic [DEPTH-1:0][PW-1:0] stk_q;
    logic [SPW-1:0]           sp_q;
    logic [SPW-1:0]           sp_mid;

    // Stack pointer after the pop part of this cycle.
    always_comb begin
        sp_mid = (pop && sp_q != '0) ? sp_q - SPW'(1) : sp_q;
    end

    // Entry and pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stk_q <= '0;
            sp_q  <= '0;
        end else if (push && sp_mid < SPW'(DEPTH)) begin
            stk_q[sp_mid[$clog2(DEPTH)-1:0]] <= push_lvl;
            sp_q <= sp_mid + SPW'(1);
        end else begin
            sp_q <= sp_mid;
        end
    end

    // Effective current level seen by the eligibility compare.
    always_comb begin
        if (sp_q == '0) cur_eff = '0;
        else            cur_eff = {1'b0, stk_q[sp_q[$clog2(DEPTH)-1:0] - 1'b1]} + (PW+1)'(1);
    end

    assign depth = sp_q;
endmodule

// File: rtl/prio_vic.sv
// Top: prioritized vectored interrupt controller. Source 0 is the fast
// line, sources 1..N_EXT the external lines, the rest peripheral lines.
// Decodes configuration writes, forms the eligibility and vector output,
// and drives the acknowledge side effects. NSRC must not exceed 32.
module prio_vic
    import prio_vic_pkg::*;
#(
    parameter int N_EXT    = 6,
    parameter int N_PERIPH = 9,
    parameter int VW       = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fiq_line,
    input  logic [N_EXT-1:0]    ext_irq,
    input  logic [N_PERIPH-1:0] periph_irq,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [VW-1:0]       cfg_wdata,
    input  logic                ack_rd,
    input  logic                fiq_ack,
    output logic                irq_o,
    output logic                fiq_o,
    output logic [VW-1:0]       vec_out,
    output logic [VW-1:0]       fiq_vec
);
    localparam int NSRC  = 1 + N_EXT + N_PERIPH;
    localparam int SW    = $clog2(NSRC);
    localparam int DEPTH = 1 << PRIO_W;
    localparam int SPW   = $clog2(DEPTH + 1);

    logic [2:0]                    op;
    logic [IDX_W-1:0]              idx;
    logic                          ctl_we, vec_we, eoi_w;
    logic [NSRC-1:0]               lines, pend, en, clr, req;
    logic [NSRC-1:0][PRIO_W-1:0]   prio;
    logic [NSRC-1:0][VW-1:0]       vec;
    logic                          win_valid, eligible, ack_take;
    logic [SW-1:0]                 win_idx;
    logic [PRIO_W-1:0]             win_prio;
    logic [PRIO_W:0]               cur_eff;
    logic [SPW-1:0]                depth;
    logic [VW-1:0]                 spur_q;
    logic                          protect_q;
    logic                          en0;

    assign op     = cfg_addr[ADDR_W-1:IDX_W];
    assign idx    = cfg_addr[IDX_W-1:0];
    assign ctl_we = cfg_we && op == OP_CTL;
    assign vec_we = cfg_we && op == OP_VEC;
    assign eoi_w  = cfg_we && op == OP_EOI;
    assign lines  = {periph_irq, ext_irq, fiq_line};
    assign req    = {pend[NSRC-1:1], 1'b0};
    assign en0    = en[0];

    vic_src_bank #(.NSRC(NSRC), .PW(PRIO_W), .VW(VW)) u_bank (
        .clk(clk), .rst_n(rst_n), .lines(lines), .ctl_we(ctl_we),
        .vec_we(vec_we), .idx(idx), .wdata(cfg_wdata), .clr(clr),
        .pend(pend), .en(en), .prio(prio), .vec(vec)
    );

    vic_arbiter #(.NSRC(NSRC), .PW(PRIO_W)) u_arb (
        .req(req), .prio(prio), .win_valid(win_valid),
        .win_idx(win_idx), .win_prio(win_prio)
    );

    vic_level_stack #(.PW(PRIO_W), .DEPTH(DEPTH)) u_stk (
        .clk(clk), .rst_n(rst_n), .push(ack_take), .pop(eoi_w),
        .push_lvl(win_prio), .cur_eff(cur_eff), .depth(depth)
    );

    // Spurious vector and protect bit registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spur_q    <= '0;
            protect_q <= 1'b0;
        end else if (cfg_we) begin
            if (op == OP_SPUR) spur_q    <= cfg_wdata;
            if (op == OP_PROT) protect_q <= cfg_wdata[0];
        end
    end

    // Winner is eligible only above the level currently in service.
    assign eligible = win_valid && ({1'b0, win_prio} >= cur_eff);
    assign ack_take = ack_rd && !protect_q && eligible;

    // Edge-latch clears caused by acknowledges.
    always_comb begin
        clr = '0;
        if (ack_take)              clr[win_idx] = 1'b1;
        if (fiq_ack && !protect_q) clr[0]       = 1'b1;
    end

    assign irq_o   = eligible;
    assign vec_out = eligible ? vec[win_idx] : spur_q;
    assign fiq_o   = pend[0];
    assign fiq_vec = vec[0];
endmodule

// File: rtl/prio_vic_chk.sv
// Checker: temporal properties of the interrupt controller, bound to the top.
module prio_vic_chk #(
    parameter int VW    = 32,
    parameter int DEPTH = 8,
    parameter int SPW   = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           ack_rd,
    input logic           eoi_w,
    input logic           protect_q,
    input logic           eligible,
    input logic [SPW-1:0] depth,
    input logic [VW-1:0]  vec_out,
    input logic [VW-1:0]  spur_q,
    input logic           fiq_o,
    input logic           en0
);
    a_r4_push: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && !protect_q && eligible && !eoi_w) |=> depth == $past(depth) + SPW'(1));
    a_r5_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_w && !(ack_rd && !protect_q && eligible) && depth != '0)
        |=> depth == $past(depth) - SPW'(1));
    a_r9_protect_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && protect_q && !eoi_w) |=> $stable(depth));
    a_r10_swap_depth: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_w && ack_rd && !protect_q && eligible && depth != '0) |=> $stable(depth));
    a_r7_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !eligible |-> vec_out == spur_q);
    a_r2_fiq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> en0);
    a_r4_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= SPW'(DEPTH));
endmodule

bind prio_vic prio_vic_chk #(.VW(VW), .DEPTH(DEPTH), .SPW(SPW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ack_rd(ack_rd), .eoi_w(eoi_w),
    .protect_q(protect_q), .eligible(eligible), .depth(depth),
    .vec_out(vec_out), .spur_q(spur_q), .fiq_o(fiq_o), .en0(en0)
);

// File: tb/prio_vic_tb.sv
`timescale 1ns/100ps
// Bench: scoreboard of expected vectors pushed by the acknowledge driver
// and popped by a monitor; direct checks on the request outputs.
module prio_vic_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fiq_line = 1'b0;
    logic [5:0]  ext_irq = '0;
    logic [8:0]  periph_irq = '0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        ack_rd = 1'b0;
    logic        fiq_ack = 1'b0;
    logic        irq_o, fiq_o;
    logic [31:0] vec_out, fiq_vec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    prio_vic u_dut (
        .clk(clk), .rst_n(rst_n), .fiq_line(fiq_line), .ext_irq(ext_irq),
        .periph_irq(periph_irq), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ack_rd(ack_rd), .fiq_ack(fiq_ack),
        .irq_o(irq_o), .fiq_o(fiq_o), .vec_out(vec_out), .fiq_vec(fiq_vec)
    );

    function automatic logic [31:0] vec_of(int s);
        return 32'h100 + 32'(s) * 4;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg(input int op, input int idx, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = {3'(op), 5'(idx)}; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
    endtask

    task automatic set_src(int s, int p, bit edg, bit en);
        cfg(0, s, 32'((int'(en) << 4) | (int'(edg) << 3) | p));
    endtask

    task automatic eoi();
        cfg(4, 0, 32'h0);
    endtask

    // Driver: queue the expected vector and pulse the acknowledge.
    task automatic ack(string req, logic [31:0] exp, bit with_eoi = 1'b0);
        @(negedge clk);
        exp_q.push_back(exp); tag_q.push_back(req);
        ack_rd = 1'b1;
        if (with_eoi) begin cfg_we = 1'b1; cfg_addr = {3'd4, 5'd0}; end
        @(negedge clk);
        ack_rd = 1'b0; cfg_we = 1'b0;
        #1;
    endtask

    // Monitor: compare the vector seen during each acknowledge cycle.
    always begin
        @(negedge clk);
        #1;
        if (ack_rd) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL scoreboard unexpected read actual=%h expected=none", vec_out);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, vec_out, e);
            end
        end
    end

    task automatic pulse_periph(int b);
        @(negedge clk); periph_irq[b] = 1'b1;
        @(negedge clk); periph_irq[b] = 1'b0;
        #1;
    endtask

    initial begin
        #500000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1 irq_o", 32'(irq_o), 0);
        check("R1 fiq_o", 32'(fiq_o), 0);
        check("R1 vec_out", vec_out, 0);
        for (int s = 0; s < 16; s++) cfg(1, s, vec_of(s));
        cfg(2, 0, 32'hDEAD0000);
        // R7: spurious read with nothing pending
        ack("R7 spurious empty", 32'hDEAD0000);
        // R2: masked source stays silent
        set_src(3, 2, 0, 0);
        @(negedge clk); ext_irq[2] = 1'b1; #1;
        check("R2 masked irq", 32'(irq_o), 0);
        set_src(3, 2, 0, 1);
        check("R2 enabled irq", 32'(irq_o), 1);
        // R3: highest priority, tie broken by lowest number
        set_src(5, 5, 0, 1);
        set_src(9, 5, 0, 1);
        @(negedge clk); ext_irq[4] = 1'b1; periph_irq[2] = 1'b1; #1;
        check("R3 winner", vec_out, vec_of(5));
        ack("R3 ack tie", vec_of(5));
        check("R4 same prio blocked", 32'(irq_o), 0);
        set_src(12, 7, 0, 1);
        @(negedge clk); periph_irq[5] = 1'b1; #1;
        check("R4 higher preempts", 32'(irq_o), 1);
        ack("R4 ack nested", vec_of(12));
        check("R4 top blocks", 32'(irq_o), 0);
        @(negedge clk); periph_irq[5] = 1'b0; #1;
        eoi();
        check("R5 restore level 5", 32'(irq_o), 0);
        eoi();
        check("R5 empty irq", 32'(irq_o), 1);
        check("R5 empty vec", vec_out, vec_of(5));
        @(negedge clk); ext_irq[4] = 1'b0; periph_irq[2] = 1'b0; #1;
        check("R6 level follows line", vec_out, vec_of(3));
        // R9: protected reads have no side effects
        cfg(3, 0, 32'h1);
        ack("R9 protected read 1", vec_of(3));
        check("R9 irq kept", 32'(irq_o), 1);
        ack("R9 protected read 2", vec_of(3));
        cfg(3, 0, 32'h0);
        ack("R4 ack level 2", vec_of(3));
        check("R4 served blocks", 32'(irq_o), 0);
        eoi();
        @(negedge clk); ext_irq[2] = 1'b0; #1;
        check("R6 level dropped", 32'(irq_o), 0);
        // R6: edge latch
        set_src(7, 4, 1, 1);
        pulse_periph(0);
        check("R6 edge latched", 32'(irq_o), 1);
        cfg(3, 0, 32'h1);
        ack("R9 protected edge read", vec_of(7));
        check("R9 edge kept", 32'(irq_o), 1);
        cfg(3, 0, 32'h0);
        ack("R6 edge ack", vec_of(7));
        eoi();
        check("R6 edge cleared", 32'(irq_o), 0);
        // R8: fast path
        set_src(0, 7, 0, 1);
        @(negedge clk); fiq_line = 1'b1; #1;
        check("R8 fiq_o", 32'(fiq_o), 1);
        check("R8 no irq", 32'(irq_o), 0);
        check("R8 fiq_vec", fiq_vec, vec_of(0));
        set_src(0, 7, 0, 0);
        check("R2 fiq masked", 32'(fiq_o), 0);
        @(negedge clk); fiq_line = 1'b0;
        set_src(0, 7, 1, 1);
        @(negedge clk); fiq_line = 1'b1;
        @(negedge clk); fiq_line = 1'b0; #1;
        check("R8 fiq edge latched", 32'(fiq_o), 1);
        @(negedge clk); fiq_ack = 1'b1;
        @(negedge clk); fiq_ack = 1'b0; #1;
        check("R8 fiq_ack clears", 32'(fiq_o), 0);
        // R10: acknowledge and end-of-interrupt together
        set_src(4, 3, 0, 1);
        set_src(10, 6, 0, 1);
        @(negedge clk); ext_irq[3] = 1'b1; #1;
        ack("R10 first", vec_of(4));
        @(negedge clk); periph_irq[3] = 1'b1; #1;
        check("R10 higher pending", 32'(irq_o), 1);
        ack("R10 same-cycle vector", vec_of(10), 1'b1);
        @(negedge clk); periph_irq[3] = 1'b0; #1;
        check("R10 top replaced", 32'(irq_o), 0);
        eoi();
        check("R10 after pop irq", 32'(irq_o), 1);
        check("R10 after pop vec", vec_out, vec_of(4));
        // R5: EOI on empty stack is harmless
        eoi();
        ack("R5 still eligible", vec_of(4));
        eoi(); eoi();
        check("R5 empty eoi", 32'(irq_o), 1);
        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule